// File: doc/BRIEF.md
# Double-Buffered PWM Output Channel

This block is one timer channel that turns a free-running counter, shared with other channels over a bus, into a pulse-width-modulated output. There are two compare registers. A match against the first one starts the pulse (the leading edge). A match against the second one ends it (the trailing edge). Software never writes a compare value straight into the comparator. Each value first goes into a buffer stage. It moves to the active comparator either on the next clock or only when the leading-edge compare matches, so a duty-cycle change never lands partway through a pulse.

A 7-bit mode field enables the channel. Its lowest bit picks the transfer rule, and bit 1 picks which matches raise the sticky event flag. An update-enable input can freeze both active comparators while software refills the buffers. A polarity input chooses whether the pulse is driven high or low.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: The channel is enabled only when mode[6:2] equals 5'b01000. With any other mode value, pwm_out, flag and both active compare values keep their state.
- R2: When the channel is enabled and cnt_bus equals the active leading-edge value, pwm_out is at the active level after the next rising clock edge, unless R3 also applies.
- R3: When the channel is enabled and cnt_bus equals the active trailing-edge value, pwm_out is at the inactive level after the next rising clock edge. This rule wins when both compare values match at once.
- R4: The inactive level of pwm_out equals edge_pol and the active level is its inverse. So edge_pol=0 gives a high pulse and edge_pol=1 gives a low pulse.
- R5: With mode[1]=0, only a trailing-edge match sets flag. With mode[1]=1, either match sets it. flag rises after the clock edge that ends the matching cycle.
- R6: flag stays set until a cycle with flag_clr=1 clears it. If a set and a clear happen in the same cycle, the set wins.
- R7: A cycle with wr_en=1 writes wr_data into the leading-edge buffer when wr_sel=0, or into the trailing-edge buffer when wr_sel=1. The active values do not change on that edge.
- R8: With mode[0]=0 and upd_en=1, each active value takes its buffer's content on every clock edge. A written value therefore compares from the second edge after the write.
- R9: With mode[0]=1 and upd_en=1, both active values take their buffers' contents only on the edge that ends a leading-edge match cycle.
- R10: With upd_en=0, neither active value changes, whatever is written to the buffers.
- R11: Reset (rst_n low) clears both buffers, both active values and flag, and drives pwm_out to the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_bus | input | CNT_W (24) | Shared counter value |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 1 | Buffer select: 0 leading edge, 1 trailing edge |
| wr_data | input | CNT_W (24) | Buffer write data |
| upd_en | input | 1 | Allows buffer-to-active transfers |
| mode | input | 7 | Channel mode field |
| edge_pol | input | 1 | Output polarity; also the inactive level |
| flag_clr | input | 1 | Write-one clear of flag |
| pwm_out | output | 1 | PWM output pin |
| flag | output | 1 | Sticky event flag |

## Verification
The bench builds the block with its default 24-bit counter width. It drives cnt_bus directly, so it can place exact, equal or near-miss compare values on any cycle without waiting for a counter to wrap. This also makes the coincident-match priority case and both transfer rules cheap to reach. Because the active compare values are not visible at the ports, the bench shows which value is active from the edge at which pwm_out changes.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int unsigned MODE_W = 7;
  localparam logic [4:0] CHAN_SIG = 5'b01000;

  typedef enum logic {
    XFER_EVERY_CYCLE = 1'b0,
    XFER_AT_LEAD     = 1'b1
  } xfer_rule_e;

  typedef enum logic {
    FLAG_TRAIL_ONLY = 1'b0,
    FLAG_ANY_EDGE   = 1'b1
  } flag_rule_e;

  typedef struct packed {
    logic       on;
    xfer_rule_e xfer;
    flag_rule_e frule;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d.on    = (m[MODE_W-1:2] == CHAN_SIG);
    d.xfer  = xfer_rule_e'(m[0]);
    d.frule = flag_rule_e'(m[1]);
    return d;
  endfunction
endpackage

// File: rtl/pwm_cmp_stage.sv
module pwm_cmp_stage #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         xfer,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] act_q,
  output logic         hit
);
  logic [W-1:0] buf_q, buf_d, act_d;

  always_comb begin
    buf_d = buf_q;
    if (buf_we) buf_d = buf_wd;
  end

  always_comb begin
    act_d = act_q;
    if (xfer) act_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (buf_we) buf_q <= buf_d;
      if (xfer)   act_q <= act_d;
    end
  end

  assign hit = (cnt == act_q);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic lead_hit,
  input  logic trail_hit,
  input  logic any_edge_flag,
  input  logic flag_clr,
  input  logic edge_pol,
  output logic pwm_out,
  output logic flag
);
  logic act_q, act_d, act_en;
  logic flg_q, flg_d, flg_set, flg_en;

  always_comb begin
    act_en = on && (lead_hit || trail_hit);
    act_d  = act_q;
    if (trail_hit)     act_d = 1'b0;
    else if (lead_hit) act_d = 1'b1;
  end

  always_comb begin
    flg_set = on && (trail_hit || (any_edge_flag && lead_hit));
    flg_en  = flg_set || flag_clr;
    flg_d   = flg_set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      if (act_en) act_q <= act_d;
      if (flg_en) flg_q <= flg_d;
    end
  end

  assign pwm_out = act_q ^ edge_pol;
  assign flag    = flg_q;
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_bus,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              upd_en,
  input  logic [MODE_W-1:0] mode,
  input  logic              edge_pol,
  input  logic              flag_clr,
  output logic              pwm_out,
  output logic              flag
);
  localparam int unsigned N_CMP = 2;

  mode_dec_t        md;
  logic [N_CMP-1:0] hit_v;
  logic [CNT_W-1:0] act_v [N_CMP];
  logic             xfer;
  logic [CNT_W-1:0] lead_act, trail_act;

  assign md = decode_mode(mode);

  always_comb begin
    xfer = 1'b0;
    if (md.on && upd_en) begin
      if (md.xfer == XFER_EVERY_CYCLE) xfer = 1'b1;
      else                             xfer = hit_v[0];
    end
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    pwm_cmp_stage #(.W(CNT_W)) cmp_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .buf_we (wr_en && (wr_sel == 1'(g))),
      .buf_wd (wr_data),
      .xfer   (xfer),
      .cnt    (cnt_bus),
      .act_q  (act_v[g]),
      .hit    (hit_v[g])
    );
  end

  assign lead_act  = act_v[0];
  assign trail_act = act_v[1];

  pwm_out_stage out_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .on            (md.on),
    .lead_hit      (hit_v[0]),
    .trail_hit     (hit_v[1]),
    .any_edge_flag (md.frule == FLAG_ANY_EDGE),
    .flag_clr      (flag_clr),
    .edge_pol      (edge_pol),
    .pwm_out       (pwm_out),
    .flag          (flag)
  );
endmodule

// File: rtl/pwm_dbuf_chan_chk.sv
module pwm_dbuf_chan_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_bus,
  input logic             upd_en,
  input logic [6:0]       mode,
  input logic             edge_pol,
  input logic             flag_clr,
  input logic             pwm_out,
  input logic             flag,
  input logic [CNT_W-1:0] lead_act,
  input logic [CNT_W-1:0] trail_act
);
  logic on;
  assign on = (mode[6:2] == 5'b01000);

  assert_trail_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (on && cnt_bus == trail_act && $stable(edge_pol)) |=> (pwm_out == edge_pol));

  assert_lead_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (on && cnt_bus == lead_act && cnt_bus != trail_act && $stable(edge_pol))
      |=> (pwm_out != edge_pol));

  assert_trail_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (on && cnt_bus == trail_act) |=> flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_frozen_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> ($stable(lead_act) && $stable(trail_act)));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !flag_clr) |=> ($stable(flag) && $stable(lead_act) && $stable(trail_act)));
endmodule

bind pwm_dbuf_chan pwm_dbuf_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_bus   (cnt_bus),
  .upd_en    (upd_en),
  .mode      (mode),
  .edge_pol  (edge_pol),
  .flag_clr  (flag_clr),
  .pwm_out   (pwm_out),
  .flag      (flag),
  .lead_act  (lead_act),
  .trail_act (trail_act)
);

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb_top;
  localparam int unsigned W = 24;
  localparam logic [W-1:0] IDLE = 24'h800000;
  localparam logic [6:0] M_IMM_B  = 7'b0100000;
  localparam logic [6:0] M_DEF_B  = 7'b0100001;
  localparam logic [6:0] M_IMM_AB = 7'b0100010;

  logic clk, rst_n, wr_en, wr_sel, upd_en, edge_pol, flag_clr;
  logic [W-1:0] cnt_bus, wr_data;
  logic [6:0] mode;
  logic pwm_out, flag;
  int n_chk, n_bad;

  pwm_dbuf_chan #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .upd_en(upd_en), .mode(mode),
    .edge_pol(edge_pol), .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] c);
    cnt_bus = c;
    @(posedge clk);
    @(negedge clk);
    cnt_bus = IDLE;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr();
    flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 out", pwm_out, 1'b0);
    check("R11 flag", flag, 1'b0);
  endtask

  task automatic t_basic();
    mode = M_IMM_B;
    wr(1'b0, 24'h10);
    check("R7 write does not move active", pwm_out, 1'b0);
    wr(1'b1, 24'h20);
    step(IDLE);
    step(24'h10);
    check("R2 lead edge", pwm_out, 1'b1);
    check("R5 no flag on lead", flag, 1'b0);
    step(24'h15);
    check("R2 hold", pwm_out, 1'b1);
    step(24'h20);
    check("R3 trail edge", pwm_out, 1'b0);
    check("R5 flag on trail", flag, 1'b1);
    step(IDLE);
    check("R6 sticky", flag, 1'b1);
    clr();
    check("R6 cleared", flag, 1'b0);
  endtask

  task automatic t_any_flag();
    mode = M_IMM_AB;
    step(24'h10);
    check("R5 flag on lead in any-edge rule", flag, 1'b1);
    step(24'h20);
    clr();
    mode = M_IMM_B;
  endtask

  task automatic t_polarity();
    edge_pol = 1'b1;
    #1;
    check("R4 inactive low-pulse level", pwm_out, 1'b1);
    step(24'h10);
    check("R4 active low", pwm_out, 1'b0);
    step(24'h20);
    check("R4 back inactive", pwm_out, 1'b1);
    edge_pol = 1'b0;
    clr();
  endtask

  task automatic t_equal();
    wr(1'b0, 24'h30);
    wr(1'b1, 24'h30);
    step(IDLE);
    step(24'h30);
    check("R3 equal values trail wins", pwm_out, 1'b0);
    check("R3 equal flag", flag, 1'b1);
    clr();
    wr(1'b0, 24'h10);
    wr(1'b1, 24'h20);
    step(IDLE);
  endtask

  task automatic t_immediate();
    wr(1'b1, 24'h28);
    step(24'h10);
    step(24'h20);
    check("R8 old trail replaced", pwm_out, 1'b1);
    step(24'h28);
    check("R8 new trail active", pwm_out, 1'b0);
    wr(1'b1, 24'h20);
    step(IDLE);
    clr();
  endtask

  task automatic t_deferred();
    step(24'h10);
    mode = M_DEF_B;
    wr(1'b1, 24'h40);
    step(IDLE);
    step(24'h20);
    check("R9 trail not moved before lead", pwm_out, 1'b0);
    step(24'h10);
    check("R9 lead still edges", pwm_out, 1'b1);
    step(24'h20);
    check("R9 old trail gone after lead", pwm_out, 1'b1);
    step(24'h40);
    check("R9 new trail after lead", pwm_out, 1'b0);
    mode = M_IMM_B;
    wr(1'b1, 24'h20);
    step(IDLE);
    clr();
  endtask

  task automatic t_freeze();
    upd_en = 1'b0;
    wr(1'b1, 24'h50);
    step(IDLE);
    step(24'h10);
    step(24'h50);
    check("R10 frozen ignores new trail", pwm_out, 1'b1);
    step(24'h20);
    check("R10 frozen keeps old trail", pwm_out, 1'b0);
    upd_en = 1'b1;
    step(IDLE);
    step(24'h10);
    step(24'h50);
    check("R10 release applies buffer", pwm_out, 1'b0);
    clr();
  endtask

  task automatic t_idle_mode();
    mode = 7'b0000000;
    step(24'h10);
    check("R1 disabled no edge", pwm_out, 1'b0);
    step(24'h50);
    check("R1 disabled no flag", flag, 1'b0);
    mode = M_IMM_B;
    step(24'h10);
    check("R1 enabled again", pwm_out, 1'b1);
  endtask

  task automatic t_set_wins();
    flag_clr = 1'b1;
    step(24'h50);
    flag_clr = 1'b0;
    check("R6 set beats clear", flag, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    upd_en = 1'b1; mode = 7'b0; edge_pol = 1'b0; flag_clr = 1'b0;
    cnt_bus = IDLE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_any_flag();
    t_polarity();
    t_equal();
    t_immediate();
    t_deferred();
    t_freeze();
    t_idle_mode();
    t_set_wins();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule